// File: doc/BRIEF.md
# Extension Command Dispatch Router

The router sits between a core's decode stage and a small set of on-core extension devices. Eight generic two-source, one-result command opcodes exist, numbered 0 to 7. None of them has a fixed meaning of its own. The low twelve bits of the first source operand hold a logical unit number. That number, looked up in a small build-time table, picks which of four physical device ports receives the command. The selected device decides what the command does, so every generic opcode is overloaded once per device.

When a command is accepted, the router latches the command index and both operands. It then presents them on the chosen device's request port under a valid/ready handshake. The first operand goes out whole, so the device can use the data bits above the unit number. The router waits for that device's response strobe and hands the result to the writeback port. It holds only one command in flight. A unit number missing from the table requests no device, and a fault is reported on the writeback port instead.

Top module: `ext_cmd_router`

## Requirements
- R1: After reset, no device request valid is high, the writeback valid is low and the command input is ready.
- R2: The unit number is bits 11:0 of the first operand. With default parameters, unit 0x005 selects port 0, 0x123 selects port 1, 0x800 selects port 2 and 0xFFF selects port 3. Bits above 11 do not take part in the selection. If several ports carried the same unit, the lowest port index would win.
- R3: In the cycle after a mapped command is accepted, only the selected port's request valid is high. That port carries the command index (3 bits, any value 0 to 7), the full first operand and the second operand, all unchanged.
- R4: While a request is high and not yet accepted by its device, its valid and payload stay stable.
- R5: A command whose unit is not in the table raises no device request. In the cycle after acceptance, the writeback valid and fault are both high and the writeback data is zero.
- R6: In the cycle after the selected device raises its response valid while the router is waiting, the writeback valid is high, the fault is low and the writeback data equals the device's response data.
- R7: From the acceptance of a mapped command until its writeback cycle, the command input is not ready, so at most one command is outstanding.
- R8: A response valid from a port with no command waiting on it, or raised while no command is waiting, produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered by decode |
| cmd_ready_o | output | 1 | Router can accept a command |
| cmd_op_i | input | 3 | Generic command index 0..7 |
| cmd_rs1_i | input | XLEN | First operand, unit number in bits 11:0 |
| cmd_rs2_i | input | XLEN | Second operand |
| wb_valid_o | output | 1 | Writeback result valid (one cycle) |
| wb_fault_o | output | 1 | Unmapped unit, illegal-instruction fault |
| wb_data_o | output | XLEN | Writeback result |
| dev_req_valid_o | output | NUM_PORTS | Request valid per device port |
| dev_req_ready_i | input | NUM_PORTS | Request ready per device port |
| dev_op_o | output | NUM_PORTS*3 | Command index per port |
| dev_rs1_o | output | NUM_PORTS*XLEN | First operand per port |
| dev_rs2_o | output | NUM_PORTS*XLEN | Second operand per port |
| dev_rsp_valid_i | input | NUM_PORTS | Response valid per device port |
| dev_rsp_data_i | input | NUM_PORTS*XLEN | Response data per device port |

## Verification
A mapped command shows its request exactly one cycle after the accepting edge. A fault writeback is due in that same next cycle. A result writeback is due one cycle after the edge on which the device's response strobe is sampled. Every input is driven on the falling edge, and every check is made on the next falling edge after the edge that should cause the change. The driver checks the request and fault timing, and each device model checks payload stability and result timing. A scoreboard queue matches every writeback, in order, against the value the bench's own device model predicts.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

    localparam int UNIT_W = 12;
    localparam int OP_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ecr_state_e;

endpackage

// File: rtl/ecr_unit_map.sv
module ecr_unit_map
    import ecr_pkg::*;
#(
    parameter int                          NUM_PORTS  = 4,
    parameter logic [NUM_PORTS*UNIT_W-1:0] PORT_UNITS = '0,
    localparam int                         PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [UNIT_W-1:0] unit_i,
    output logic              hit_o,
    output logic [PORT_W-1:0] port_o
);

    logic [NUM_PORTS-1:0] match;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
        assign match[p] = (unit_i == PORT_UNITS[p*UNIT_W +: UNIT_W]);
    end

    // lowest matching port wins (R2)
    always_comb begin
        hit_o  = 1'b0;
        port_o = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (match[p]) begin
                hit_o  = 1'b1;
                port_o = PORT_W'(p);
            end
        end
    end

endmodule

// File: rtl/ecr_req_fanout.sv
module ecr_req_fanout
    import ecr_pkg::*;
#(
    parameter int  NUM_PORTS = 4,
    parameter int  XLEN      = 32,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        req_valid_i,
    input  logic [PORT_W-1:0]           port_i,
    input  logic [OP_W-1:0]             op_i,
    input  logic [XLEN-1:0]             rs1_i,
    input  logic [XLEN-1:0]             rs2_i,
    output logic                        req_ready_o,
    output logic [NUM_PORTS-1:0]        dev_valid_o,
    input  logic [NUM_PORTS-1:0]        dev_ready_i,
    output logic [NUM_PORTS*OP_W-1:0]   dev_op_o,
    output logic [NUM_PORTS*XLEN-1:0]   dev_rs1_o,
    output logic [NUM_PORTS*XLEN-1:0]   dev_rs2_o
);

    logic [NUM_PORTS-1:0] sel;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign sel[p]                        = (port_i == PORT_W'(p));
        assign dev_valid_o[p]                = req_valid_i && sel[p];
        assign dev_op_o[p*OP_W +: OP_W]      = sel[p] ? op_i  : '0;
        assign dev_rs1_o[p*XLEN +: XLEN]     = sel[p] ? rs1_i : '0;
        assign dev_rs2_o[p*XLEN +: XLEN]     = sel[p] ? rs2_i : '0;
    end

    assign req_ready_o = |(dev_ready_i & sel);

endmodule

// File: rtl/ecr_rsp_select.sv
module ecr_rsp_select #(
    parameter int  NUM_PORTS = 4,
    parameter int  XLEN      = 32,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [PORT_W-1:0]         port_i,
    input  logic [NUM_PORTS-1:0]      rsp_valid_i,
    input  logic [NUM_PORTS*XLEN-1:0] rsp_data_i,
    output logic                      rsp_valid_o,
    output logic [XLEN-1:0]           rsp_data_o
);

    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_data_o  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_i == PORT_W'(p)) begin
                rsp_valid_o = rsp_valid_i[p];
                rsp_data_o  = rsp_data_i[p*XLEN +: XLEN];
            end
        end
    end

endmodule

// File: rtl/ext_cmd_router.sv
module ext_cmd_router
    import ecr_pkg::*;
#(
    parameter int                          NUM_PORTS  = 4,
    parameter int                          XLEN       = 32,
    parameter logic [NUM_PORTS*UNIT_W-1:0] PORT_UNITS = {12'hFFF, 12'h800, 12'h123, 12'h005}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid_i,
    output logic                        cmd_ready_o,
    input  logic [2:0]                  cmd_op_i,
    input  logic [XLEN-1:0]             cmd_rs1_i,
    input  logic [XLEN-1:0]             cmd_rs2_i,
    output logic                        wb_valid_o,
    output logic                        wb_fault_o,
    output logic [XLEN-1:0]             wb_data_o,
    output logic [NUM_PORTS-1:0]        dev_req_valid_o,
    input  logic [NUM_PORTS-1:0]        dev_req_ready_i,
    output logic [NUM_PORTS*3-1:0]      dev_op_o,
    output logic [NUM_PORTS*XLEN-1:0]   dev_rs1_o,
    output logic [NUM_PORTS*XLEN-1:0]   dev_rs2_o,
    input  logic [NUM_PORTS-1:0]        dev_rsp_valid_i,
    input  logic [NUM_PORTS*XLEN-1:0]   dev_rsp_data_i
);

    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        ecr_state_e        state;
        logic [PORT_W-1:0] port;
        logic [OP_W-1:0]   op;
        logic [XLEN-1:0]   rs1;
        logic [XLEN-1:0]   rs2;
        logic              wb_valid;
        logic              wb_fault;
        logic [XLEN-1:0]   wb_data;
    } router_regs_t;

    router_regs_t r_d, r_q;

    logic              map_hit;
    logic [PORT_W-1:0] map_port;
    logic              sel_ready;
    logic              sel_rsp_valid;
    logic [XLEN-1:0]   sel_rsp_data;

    ecr_unit_map #(
        .NUM_PORTS  (NUM_PORTS),
        .PORT_UNITS (PORT_UNITS)
    ) u_map (
        .unit_i (cmd_rs1_i[UNIT_W-1:0]),
        .hit_o  (map_hit),
        .port_o (map_port)
    );

    ecr_req_fanout #(
        .NUM_PORTS (NUM_PORTS),
        .XLEN      (XLEN)
    ) u_fanout (
        .req_valid_i (r_q.state == ST_REQ),
        .port_i      (r_q.port),
        .op_i        (r_q.op),
        .rs1_i       (r_q.rs1),
        .rs2_i       (r_q.rs2),
        .req_ready_o (sel_ready),
        .dev_valid_o (dev_req_valid_o),
        .dev_ready_i (dev_req_ready_i),
        .dev_op_o    (dev_op_o),
        .dev_rs1_o   (dev_rs1_o),
        .dev_rs2_o   (dev_rs2_o)
    );

    ecr_rsp_select #(
        .NUM_PORTS (NUM_PORTS),
        .XLEN      (XLEN)
    ) u_rsp (
        .port_i      (r_q.port),
        .rsp_valid_i (dev_rsp_valid_i),
        .rsp_data_i  (dev_rsp_data_i),
        .rsp_valid_o (sel_rsp_valid),
        .rsp_data_o  (sel_rsp_data)
    );

    always_comb begin
        r_d          = r_q;
        r_d.wb_valid = 1'b0;
        r_d.wb_fault = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    if (map_hit) begin
                        r_d.state = ST_REQ;
                        r_d.port  = map_port;
                        r_d.op    = cmd_op_i;
                        r_d.rs1   = cmd_rs1_i;
                        r_d.rs2   = cmd_rs2_i;
                    end else begin
                        r_d.wb_valid = 1'b1;
                        r_d.wb_fault = 1'b1;
                        r_d.wb_data  = '0;
                    end
                end
            end
            ST_REQ: begin
                if (sel_ready) begin
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sel_rsp_valid) begin
                    r_d.state    = ST_IDLE;
                    r_d.wb_valid = 1'b1;
                    r_d.wb_data  = sel_rsp_data;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready_o = (r_q.state == ST_IDLE);
    assign wb_valid_o  = r_q.wb_valid;
    assign wb_fault_o  = r_q.wb_fault;
    assign wb_data_o   = r_q.wb_data;

endmodule

// File: rtl/ecr_checker.sv
module ecr_checker #(
    parameter int NUM_PORTS = 4,
    parameter int XLEN      = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid_i,
    input logic                      cmd_ready_o,
    input logic                      wb_valid_o,
    input logic                      wb_fault_o,
    input logic [XLEN-1:0]           wb_data_o,
    input logic [NUM_PORTS-1:0]      dev_req_valid_o,
    input logic [NUM_PORTS-1:0]      dev_req_ready_i,
    input logic [NUM_PORTS*3-1:0]    dev_op_o,
    input logic [NUM_PORTS*XLEN-1:0] dev_rs1_o,
    input logic [NUM_PORTS*XLEN-1:0] dev_rs2_o,
    input logic [NUM_PORTS-1:0]      dev_rsp_valid_i
);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (dev_req_valid_o == '0 && !wb_valid_o && cmd_ready_o));

    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_req_valid_o));

    a_r4_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dev_req_valid_o & ~dev_req_ready_i)) |=>
            ($stable(dev_req_valid_o) && $stable(dev_op_o) &&
             $stable(dev_rs1_o) && $stable(dev_rs2_o)));

    a_r5_fault_or_request: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o) |=>
            ((wb_valid_o && wb_fault_o) != (|dev_req_valid_o)));

    a_r5_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        wb_fault_o |-> (wb_valid_o && wb_data_o == '0));

    a_r6_result_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !wb_fault_o) |-> $past(|dev_rsp_valid_i));

    a_r7_busy_while_request: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_req_valid_o) |-> !cmd_ready_o);

endmodule

bind ext_cmd_router ecr_checker #(
    .NUM_PORTS (NUM_PORTS),
    .XLEN      (XLEN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid_i     (cmd_valid_i),
    .cmd_ready_o     (cmd_ready_o),
    .wb_valid_o      (wb_valid_o),
    .wb_fault_o      (wb_fault_o),
    .wb_data_o       (wb_data_o),
    .dev_req_valid_o (dev_req_valid_o),
    .dev_req_ready_i (dev_req_ready_i),
    .dev_op_o        (dev_op_o),
    .dev_rs1_o       (dev_rs1_o),
    .dev_rs2_o       (dev_rs2_o),
    .dev_rsp_valid_i (dev_rsp_valid_i)
);

// File: tb/ext_cmd_router_tb.sv
module ext_cmd_router_tb;

    localparam int NP = 4;
    localparam int XL = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [2:0]      cmd_op = '0;
    logic [XL-1:0]   cmd_rs1 = '0;
    logic [XL-1:0]   cmd_rs2 = '0;
    logic            wb_valid, wb_fault;
    logic [XL-1:0]   wb_data;
    logic [NP-1:0]   req_valid, req_ready, rsp_valid;
    logic [NP*3-1:0] d_op;
    logic [NP*XL-1:0] d_rs1, d_rs2, rsp_data;

    logic            mdl_rdy [NP];
    logic            mdl_rv  [NP];
    logic [XL-1:0]   mdl_data[NP];
    logic [NP-1:0]   spur_v = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int lat_rdy = 0;
    int lat_rsp = 0;
    logic [2:0]    exp_op;
    logic [XL-1:0] exp_rs1, exp_rs2;

    typedef struct { logic fault; logic [XL-1:0] data; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    for (genvar p = 0; p < NP; p++) begin : g_pack
        assign req_ready[p]              = mdl_rdy[p];
        assign rsp_valid[p]              = mdl_rv[p] | spur_v[p];
        assign rsp_data[p*XL +: XL]      = mdl_data[p];
    end

    ext_cmd_router #(.NUM_PORTS(NP), .XLEN(XL)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_valid_i     (cmd_valid),
        .cmd_ready_o     (cmd_ready),
        .cmd_op_i        (cmd_op),
        .cmd_rs1_i       (cmd_rs1),
        .cmd_rs2_i       (cmd_rs2),
        .wb_valid_o      (wb_valid),
        .wb_fault_o      (wb_fault),
        .wb_data_o       (wb_data),
        .dev_req_valid_o (req_valid),
        .dev_req_ready_i (req_ready),
        .dev_op_o        (d_op),
        .dev_rs1_o       (d_rs1),
        .dev_rs2_o       (d_rs2),
        .dev_rsp_valid_i (rsp_valid),
        .dev_rsp_data_i  (rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [XL-1:0] act,
                         input logic [XL-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R2: unit table as stated in the requirement
    function automatic int map_unit(input logic [11:0] u);
        case (u)
            12'h005: return 0;
            12'h123: return 1;
            12'h800: return 2;
            12'hFFF: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [XL-1:0] dev_fn(input int p, input logic [2:0] op,
                                             input logic [XL-1:0] a, input logic [XL-1:0] b);
        return (a ^ {b[15:0], b[31:16]}) + {27'd0, op, 2'(p)};
    endfunction

    // device models
    for (genvar p = 0; p < NP; p++) begin : g_dev
        initial begin
            mdl_rdy[p]  = 1'b0;
            mdl_rv[p]   = 1'b0;
            mdl_data[p] = '0;
            forever begin
                @(negedge clk);
                if (rst_n && req_valid[p]) begin
                    check(d_op[p*3 +: 3] == exp_op, "R3 op", XL'(d_op[p*3 +: 3]), XL'(exp_op));
                    check(d_rs1[p*XL +: XL] == exp_rs1, "R3 rs1", d_rs1[p*XL +: XL], exp_rs1);
                    check(d_rs2[p*XL +: XL] == exp_rs2, "R3 rs2", d_rs2[p*XL +: XL], exp_rs2);
                    for (int i = 0; i < lat_rdy; i++) begin
                        @(negedge clk);
                        check(req_valid[p] && d_rs1[p*XL +: XL] == exp_rs1 &&
                              d_op[p*3 +: 3] == exp_op, "R4 hold",
                              d_rs1[p*XL +: XL], exp_rs1);
                    end
                    mdl_rdy[p] = 1'b1;
                    @(negedge clk);
                    mdl_rdy[p] = 1'b0;
                    check(req_valid == '0 && !cmd_ready, "R7 busy after handshake",
                          XL'({req_valid, cmd_ready}), '0);
                    for (int i = 0; i < lat_rsp; i++) @(negedge clk);
                    mdl_data[p] = dev_fn(p, exp_op, exp_rs1, exp_rs2);
                    mdl_rv[p]   = 1'b1;
                    @(negedge clk);
                    mdl_rv[p]   = 1'b0;
                    check(wb_valid && !wb_fault, "R6 writeback timing",
                          XL'({wb_valid, wb_fault}), XL'(2'b10));
                end
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected writeback", wb_data, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(wb_fault == e.fault && wb_data == e.data,
                      e.fault ? "R5 fault writeback" : "R6 result data",
                      wb_data, e.data);
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [XL-1:0] a, input logic [XL-1:0] b);
        int p;
        exp_t e;
        p = map_unit(a[11:0]);
        exp_op = op; exp_rs1 = a; exp_rs2 = b;
        e.fault = (p < 0);
        e.data  = (p < 0) ? '0 : dev_fn(p, op, a, b);
        exp_q.push_back(e);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_rs1 = a; cmd_rs2 = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (p < 0) begin
            check(req_valid == '0 && wb_valid && wb_fault, "R5 no request, fault next cycle",
                  XL'({req_valid, wb_valid, wb_fault}), XL'(2'b11));
        end else begin
            check(req_valid == NP'(1 << p), "R2 R3 selected port",
                  XL'(req_valid), XL'(1 << p));
            check(!cmd_ready, "R7 not ready while outstanding", XL'(cmd_ready), '0);
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_valid == '0 && !wb_valid && cmd_ready, "R1 reset state",
              XL'({req_valid, wb_valid, cmd_ready}), XL'(1));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_valid == '0 && !wb_valid && cmd_ready, "R1 after release",
              XL'({req_valid, wb_valid, cmd_ready}), XL'(1));

        // every op to every port with varying latencies
        for (int op = 0; op < 8; op++) begin
            logic [11:0] units [4] = '{12'h005, 12'h123, 12'h800, 12'hFFF};
            lat_rdy = op % 3;
            lat_rsp = (op * 2) % 5;
            issue(3'(op), {20'(op * 32'h1357 + 32'hA5), units[op % 4]}, 32'hC0DE_0000 + op);
        end

        // R2: upper bits of the first operand do not change the selection
        lat_rdy = 1; lat_rsp = 0;
        issue(3'd6, 32'hABC0_0123, 32'h0000_FFFF);
        issue(3'd2, 32'hFFFF_F005, 32'h1234_5678);

        // R5: unmapped units
        issue(3'd1, 32'h0000_0006, 32'h1);
        issue(3'd7, 32'h5555_5000, 32'h2);
        issue(3'd0, 32'h0000_0FFE, 32'h3);

        // R8: spurious responses while idle
        @(negedge clk);
        spur_v = '1;
        @(negedge clk);
        spur_v = '0;
        check(!wb_valid && cmd_ready, "R8 idle response ignored",
              XL'({wb_valid, cmd_ready}), XL'(1));

        // R8: response from another port while one is waiting
        lat_rdy = 0; lat_rsp = 6;
        fork
            issue(3'd4, 32'h0000_0005, 32'h9999_0000);
            begin
                @(negedge clk);
                while (!(req_valid == '0 && !cmd_ready)) @(negedge clk);
                spur_v = 4'b0100;
                @(negedge clk);
                spur_v = '0;
                check(!wb_valid, "R8 other port response ignored", XL'(wb_valid), '0);
            end
        join

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule